// File: doc/BRIEF.md
# SPI master frame timing sequencer

This block produces the chip-select and serial-clock timing for a single SPI master frame, with every interval counted in system clock cycles. A start request asserts the active-low chip select. A lead delay follows, then a burst of serial-clock edges for a frame of 4 to 16 bits, then a trail delay. Chip select is then negated and an inter-frame gap runs before the sequencer can start another frame. The block shifts no data. Instead it gives a one-cycle shift strobe and a one-cycle sample strobe, and a data path elsewhere acts on those.

Each delay is set by a 2-bit prescale code and a 4-bit scale code, and its length is the product of the two values they select. The serial-clock period is set by its own prescale set and scale code. Every setting except the lead delay is captured when a frame starts. The lead delay is used directly as the frame starts. Settings may therefore be rewritten while a frame runs without disturbing it. A start request that arrives while a frame or gap is in progress is held and served as soon as the gap expires.

Top module: `spi_frame_timer`

## Requirements
- R1: Out of reset, and whenever no frame is requested, `cs_n_o` is 1, `busy_o` is 0, both strobes are 0 and `sck_o` rests at the polarity level.
- R2: `cs_n_o` falls in the cycle after `start_i` is sampled while idle. It then stays low for exactly P×2^(S+1) cycles before the first `sck_o` change, where S is the lead scale code and P is 1, 3, 5 or 7 for lead prescale code 00, 01, 10 or 11.
- R3: Each `sck_o` level lasts B×2^S cycles, where S is the baud scale code and B is 2, 3, 5 or 7 for baud prescale code 00, 01, 10 or 11. The full period is twice that, with equal high and low halves.
- R4: A frame of N bits gives exactly 2N `sck_o` changes while `cs_n_o` is low. N is `frame_len_i` clamped to the range 4 to 16.
- R5: From the last `sck_o` change to the rise of `cs_n_o` there are exactly P×2^(S+1) cycles, using the trail codes and the odd prescale set of R2.
- R6: When another frame is pending, `cs_n_o` stays high for exactly P×2^(S+1) cycles between frames, using the gap codes and the odd prescale set of R2.
- R7: A `start_i` pulse sampled while `busy_o` is 1 is held. The next frame starts as soon as the current gap expires.
- R8: `sck_o` rests at `cpol_i` while idle. The first edge of a frame moves it to the opposite level.
- R9: With `cpha_i`=0, `sample_o` pulses on each edge that leaves the rest level and `shift_o` pulses on each edge that returns to it. With `cpha_i`=1 the two roles are swapped. Each strobe lasts one cycle, coincides with the cycle in which `sck_o` shows its new level, and occurs N times per frame.
- R10: Frame length, polarity, phase, baud, trail and gap settings are captured at frame start. Changing them during a frame has no effect on that frame.
- R11: `busy_o` is 1 from the cycle `cs_n_o` first falls until the gap after the last frame expires. It then drops in the cycle after the gap's final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start request, one cycle |
| frame_len_i | input | 5 | Bits per frame, clamped to 4..16 |
| cpol_i | input | 1 | Serial clock rest level |
| cpha_i | input | 1 | Strobe edge selection |
| lead_pre_i | input | 2 | Lead delay prescale code |
| lead_scl_i | input | 4 | Lead delay scale code |
| trail_pre_i | input | 2 | Trail delay prescale code |
| trail_scl_i | input | 4 | Trail delay scale code |
| gap_pre_i | input | 2 | Inter-frame gap prescale code |
| gap_scl_i | input | 4 | Inter-frame gap scale code |
| baud_pre_i | input | 2 | Serial clock prescale code |
| baud_scl_i | input | 4 | Serial clock scale code |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock |
| shift_o | output | 1 | One-cycle shift strobe |
| sample_o | output | 1 | One-cycle sample strobe |
| busy_o | output | 1 | Frame or gap in progress |

## Verification
Chip select drops one cycle after a start is sampled. All outputs come from registers, so `sck_o` and the strobes settle in the same cycle as the state change that causes them. The bench drives and samples on the falling clock edge and numbers each sample from the first low chip-select cycle. Lead, half period, edge count and trail are then read as differences between sample indices, and each is compared with the product formula. The gap and the fall of busy are counted from the first high chip-select sample after a frame. A pending start and mid-frame setting changes are injected at fixed sample indices inside the first frame, so every expected value is tied to a known cycle.

// File: rtl/spi_tmg_pkg.sv
package spi_tmg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } sft_state_e;

  // Delay prescale: codes 0..3 map to 1, 3, 5, 7.
  function automatic logic [2:0] odd_prescale(input logic [1:0] code);
    return {code, 1'b1};
  endfunction

  // Serial clock prescale: codes 0..3 map to 2, 3, 5, 7.
  function automatic logic [2:0] baud_prescale(input logic [1:0] code);
    logic [2:0] v;
    case (code)
      2'd0:    v = 3'd2;
      2'd1:    v = 3'd3;
      2'd2:    v = 3'd5;
      default: v = 3'd7;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sft_span.sv
module sft_span #(
  parameter int SCL_W     = 4,
  parameter int OUT_W     = 19,
  parameter bit HALF_BAUD = 1'b0
) (
  input  logic [1:0]       pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output logic [OUT_W-1:0] span
);
  import spi_tmg_pkg::*;

  generate
    if (HALF_BAUD) begin : g_baud
      // Half serial clock period: prescale x 2^scale
      always_comb begin
        span = OUT_W'(baud_prescale(pre_code)) << scl_code;
      end
    end else begin : g_delay
      // Delay: odd prescale x 2^(scale+1)
      logic [SCL_W:0] sh;
      always_comb begin
        sh   = {1'b0, scl_code} + (SCL_W+1)'(1);
        span = OUT_W'(odd_prescale(pre_code)) << sh;
      end
    end
  endgenerate

endmodule

// File: rtl/sft_strobe.sv
module sft_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic lead_i,
  input  logic cpha_i,
  output logic shift_o,
  output logic sample_o
);
  logic shift_d, sample_d;

  always_comb begin
    shift_d  = edge_i & (cpha_i ?  lead_i : ~lead_i);
    sample_d = edge_i & (cpha_i ? ~lead_i :  lead_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_o  <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      shift_o  <= shift_d;
      sample_o <= sample_d;
    end
  end

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer #(
  parameter int LEN_W    = 5,
  parameter int MIN_BITS = 4,
  parameter int MAX_BITS = 16,
  parameter int SCL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [1:0]       lead_pre_i,
  input  logic [SCL_W-1:0] lead_scl_i,
  input  logic [1:0]       trail_pre_i,
  input  logic [SCL_W-1:0] trail_scl_i,
  input  logic [1:0]       gap_pre_i,
  input  logic [SCL_W-1:0] gap_scl_i,
  input  logic [1:0]       baud_pre_i,
  input  logic [SCL_W-1:0] baud_scl_i,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             busy_o
);
  import spi_tmg_pkg::*;

  localparam int CNT_W  = 3 + (1 << SCL_W);
  localparam int HALF_W = $clog2(2 * MAX_BITS);

  // State registers
  sft_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] half_q, half_d;
  logic              pend_q, pend_d;

  // Captured frame settings
  logic [LEN_W-1:0]  nbits_q;
  logic              cpol_q, cpha_q;
  logic [1:0]        trail_pre_q, gap_pre_q, baud_pre_q;
  logic [SCL_W-1:0]  trail_scl_q, gap_scl_q, baud_scl_q;
  logic              cfg_ld;

  logic [LEN_W-1:0]  nbits_in;
  logic [LEN_W:0]    last_full;
  logic [HALF_W-1:0] last_half;
  logic [CNT_W-1:0]  lead_span, trail_span, gap_span, half_span;
  logic              edge_d, lead_d, pending;

  sft_span #(.SCL_W(SCL_W), .OUT_W(CNT_W), .HALF_BAUD(1'b0)) u_lead_span (
    .pre_code(lead_pre_i), .scl_code(lead_scl_i), .span(lead_span));
  sft_span #(.SCL_W(SCL_W), .OUT_W(CNT_W), .HALF_BAUD(1'b0)) u_trail_span (
    .pre_code(trail_pre_q), .scl_code(trail_scl_q), .span(trail_span));
  sft_span #(.SCL_W(SCL_W), .OUT_W(CNT_W), .HALF_BAUD(1'b0)) u_gap_span (
    .pre_code(gap_pre_q), .scl_code(gap_scl_q), .span(gap_span));
  sft_span #(.SCL_W(SCL_W), .OUT_W(CNT_W), .HALF_BAUD(1'b1)) u_half_span (
    .pre_code(baud_pre_q), .scl_code(baud_scl_q), .span(half_span));

  always_comb begin
    if (frame_len_i < LEN_W'(MIN_BITS))      nbits_in = LEN_W'(MIN_BITS);
    else if (frame_len_i > LEN_W'(MAX_BITS)) nbits_in = LEN_W'(MAX_BITS);
    else                                     nbits_in = frame_len_i;
    last_full = {nbits_q, 1'b0} - (LEN_W+1)'(2);
    last_half = last_full[HALF_W-1:0];
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    pending = pend_q | start_i;
    pend_d  = pending;
    cfg_ld  = 1'b0;
    edge_d  = 1'b0;
    lead_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cfg_ld = 1'b1;
        pend_d = 1'b0;
        if (start_i) begin
          state_d = ST_LEAD;
          cnt_d   = lead_span - CNT_W'(1);
        end
      end
      ST_LEAD: begin
        if (cnt_q == '0) begin
          state_d = ST_SHIFT;
          cnt_d   = half_span - CNT_W'(1);
          half_d  = '0;
          edge_d  = 1'b1;
          lead_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_SHIFT: begin
        if (cnt_q == '0) begin
          edge_d = 1'b1;
          if (half_q == last_half) begin
            state_d = ST_TRAIL;
            cnt_d   = trail_span - CNT_W'(1);
          end else begin
            half_d = half_q + HALF_W'(1);
            cnt_d  = half_span - CNT_W'(1);
            lead_d = half_q[0];
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_TRAIL: begin
        if (cnt_q == '0) begin
          state_d = ST_GAP;
          cnt_d   = gap_span - CNT_W'(1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (cnt_q == '0) begin
          pend_d = 1'b0;
          if (pending) begin
            state_d = ST_LEAD;
            cnt_d   = lead_span - CNT_W'(1);
            cfg_ld  = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Sequencer registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
      pend_q  <= pend_d;
    end
  end

  // Settings capture, enabled only at frame start or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbits_q     <= LEN_W'(MIN_BITS);
      cpol_q      <= 1'b0;
      cpha_q      <= 1'b0;
      trail_pre_q <= '0;
      trail_scl_q <= '0;
      gap_pre_q   <= '0;
      gap_scl_q   <= '0;
      baud_pre_q  <= '0;
      baud_scl_q  <= '0;
    end else if (cfg_ld) begin
      nbits_q     <= nbits_in;
      cpol_q      <= cpol_i;
      cpha_q      <= cpha_i;
      trail_pre_q <= trail_pre_i;
      trail_scl_q <= trail_scl_i;
      gap_pre_q   <= gap_pre_i;
      gap_scl_q   <= gap_scl_i;
      baud_pre_q  <= baud_pre_i;
      baud_scl_q  <= baud_scl_i;
    end
  end

  sft_strobe u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (edge_d),
    .lead_i   (lead_d),
    .cpha_i   (cpha_q),
    .shift_o  (shift_o),
    .sample_o (sample_o)
  );

  always_comb begin
    cs_n_o = (state_q == ST_IDLE) || (state_q == ST_GAP);
    busy_o = (state_q != ST_IDLE);
    sck_o  = (state_q == ST_SHIFT) ? (cpol_q ^ ~half_q[0]) : cpol_q;
  end

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic shift,
  input logic sample,
  input logic busy
);

  // R1: no strobes while chip select is negated
  assert_quiet_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(shift || sample));

  // R9: the two strobes never fire together
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && sample));

  // R9: a strobe coincides with a change of the serial clock
  assert_strobe_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift || sample) |-> (sck != $past(sck)));

  // R11: chip select can only be active while busy
  assert_select_implies_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  // R2: chip select assertion happens only with busy set
  assert_select_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> busy);

endmodule

bind spi_frame_timer sft_checker u_sft_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n_o),
  .sck    (sck_o),
  .shift  (shift_o),
  .sample (sample_o),
  .busy   (busy_o)
);

// File: tb/spi_frame_timer_bench.sv
`timescale 1ns/1ps
module spi_frame_timer_bench;

  logic       clk, rst_n, start_i, cpol_i, cpha_i;
  logic [4:0] frame_len_i;
  logic [1:0] lead_pre_i, trail_pre_i, gap_pre_i, baud_pre_i;
  logic [3:0] lead_scl_i, trail_scl_i, gap_scl_i, baud_scl_i;
  logic       cs_n_o, sck_o, shift_o, sample_o, busy_o;

  int errs, checks;
  bit done;
  int m_lead, m_half, m_edges, m_trail, m_samp, m_shift, m_bad, m_first_active;

  spi_frame_timer u_spi_frame_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i),
    .lead_pre_i(lead_pre_i), .lead_scl_i(lead_scl_i),
    .trail_pre_i(trail_pre_i), .trail_scl_i(trail_scl_i),
    .gap_pre_i(gap_pre_i), .gap_scl_i(gap_scl_i),
    .baud_pre_i(baud_pre_i), .baud_scl_i(baud_scl_i),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .shift_o(shift_o),
    .sample_o(sample_o), .busy_o(busy_o));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int dly(input int pre, input int scl);
    return (2 * pre + 1) << (scl + 1);
  endfunction

  function automatic int hlf(input int pre, input int scl);
    int b;
    case (pre)
      0: b = 2;
      1: b = 3;
      2: b = 5;
      default: b = 7;
    endcase
    return b << scl;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int len, input bit pol, input bit pha,
                         input int lp, input int ls, input int tp, input int ts,
                         input int gp, input int gs, input int bp, input int bs);
    frame_len_i = 5'(len);  cpol_i = pol;  cpha_i = pha;
    lead_pre_i  = 2'(lp);   lead_scl_i  = 4'(ls);
    trail_pre_i = 2'(tp);   trail_scl_i = 4'(ts);
    gap_pre_i   = 2'(gp);   gap_scl_i   = 4'(gs);
    baud_pre_i  = 2'(bp);   baud_scl_i  = 4'(bs);
  endtask

  task automatic kick();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Samples one frame starting at its first low chip-select sample.
  task automatic measure_frame(input bit pol, input bit pha, input bit inject);
    int idx, first, second, last, nedge;
    bit prev, s, le, te;
    idx = 0; first = -1; second = -1; last = -1; nedge = 0; prev = pol;
    m_samp = 0; m_shift = 0; m_bad = 0; m_first_active = 0;
    while (cs_n_o == 1'b0 && idx < 5000) begin
      s  = sck_o;
      le = (s != prev) && (s != pol);
      te = (s != prev) && (s == pol);
      if (s != prev) begin
        if (first < 0) begin
          first = idx;
          m_first_active = int'(s != pol);
        end else if (second < 0) begin
          second = idx;
        end
        last = idx;
        nedge++;
      end
      if (sample_o) begin
        m_samp++;
        if (pha ? !te : !le) m_bad++;
      end
      if (shift_o) begin
        m_shift++;
        if (pha ? !le : !te) m_bad++;
      end
      prev = s;
      if (inject && idx == 1) begin
        start_i = 1'b1;
        set_cfg(10, 1'b0, 1'b1, 1, 0, 0, 0, 0, 0, 1, 0);
      end
      if (inject && idx == 2) start_i = 1'b0;
      idx++;
      @(negedge clk);
    end
    m_lead = first; m_half = second - first; m_edges = nedge; m_trail = idx - last;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (cs_n_o == 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o == 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_idle();
    int bad;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (cs_n_o !== 1'b1 || busy_o !== 1'b0 || shift_o !== 1'b0 ||
          sample_o !== 1'b0 || sck_o !== 1'b0) bad++;
      @(negedge clk);
    end
    check("R1 idle outputs after reset (bad cycles)", bad, 0);
  endtask

  task automatic t_basic();
    int n;
    set_cfg(8, 1'b0, 1'b0, 0, 0, 1, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    kick();
    measure_frame(1'b0, 1'b0, 1'b0);
    check("R2 lead cycles", m_lead, dly(0, 0));
    check("R3 half period", m_half, hlf(0, 0));
    check("R4 edge count len 8", m_edges, 16);
    check("R5 trail cycles", m_trail, dly(1, 0));
    check("R9 sample count cpha0", m_samp, 8);
    check("R9 shift count cpha0", m_shift, 8);
    check("R9 strobe edge type cpha0", m_bad, 0);
    check("R8 first edge leaves rest level", m_first_active, 1);
    count_busy(n);
    check("R11 busy through gap", n, dly(0, 0));
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (cs_n_o !== 1'b1) n++;
      @(negedge clk);
    end
    check("R1 no frame without request", n, 0);
  endtask

  task automatic t_pol_pha_short();
    set_cfg(2, 1'b1, 1'b1, 3, 2, 2, 1, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    check("R8 rest level follows cpol", sck_o, 1);
    kick();
    measure_frame(1'b1, 1'b1, 1'b0);
    check("R2 lead cycles 7x8", m_lead, dly(3, 2));
    check("R3 half period 3x2", m_half, hlf(1, 1));
    check("R4 edge count clamped to 4 bits", m_edges, 8);
    check("R5 trail cycles 5x4", m_trail, dly(2, 1));
    check("R9 sample count cpha1", m_samp, 4);
    check("R9 shift count cpha1", m_shift, 4);
    check("R9 strobe edge type cpha1", m_bad, 0);
    check("R8 first edge leaves rest level cpol1", m_first_active, 1);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_long();
    set_cfg(20, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 3, 0);
    repeat (3) @(negedge clk);
    kick();
    measure_frame(1'b0, 1'b0, 1'b0);
    check("R4 edge count clamped to 16 bits", m_edges, 32);
    check("R3 half period 7", m_half, hlf(3, 0));
    check("R9 sample count 16 bits", m_samp, 16);
    repeat (20) @(negedge clk);
  endtask

  task automatic t_back_to_back();
    int n;
    set_cfg(6, 1'b0, 1'b0, 0, 0, 1, 1, 2, 1, 0, 0);
    repeat (3) @(negedge clk);
    kick();
    measure_frame(1'b0, 1'b0, 1'b1);
    check("R10 frame 1 edges unchanged", m_edges, 12);
    check("R10 frame 1 half period unchanged", m_half, hlf(0, 0));
    check("R10 frame 1 trail unchanged", m_trail, dly(1, 1));
    check("R10 frame 1 strobe types unchanged", m_bad, 0);
    count_high(n);
    check("R6 gap from captured codes", n, dly(2, 1));
    check("R7 held start launched frame 2", cs_n_o, 0);
    measure_frame(1'b0, 1'b1, 1'b0);
    check("R2 frame 2 lead from live codes", m_lead, dly(1, 0));
    check("R3 frame 2 half period", m_half, hlf(1, 0));
    check("R4 frame 2 edge count", m_edges, 20);
    check("R5 frame 2 trail", m_trail, dly(0, 0));
    check("R9 frame 2 strobe types cpha1", m_bad, 0);
    count_busy(n);
    check("R11 busy ends after frame 2 gap", n, dly(0, 0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    errs = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; start_i = 1'b0;
    set_cfg(8, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_idle();
    t_basic();
    t_pol_pha_short();
    t_long();
    t_back_to_back();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule